// File: doc/BRIEF.md
# Receive Statistics Counter Bank

This block holds the receive statistics of an Ethernet MAC. Upstream logic that has already accepted a frame sends a single-cycle event. The event carries the frame length without the FCS, the length with the FCS, and a two-bit destination kind. On each event the bank updates three groups of counters: one counter in a set of frame-size bins, the packet counters (total, good, broadcast and multicast), and two 64-bit octet counters.

None of the counters wraps: each one stops at its all-ones value. Software, or any other agent, reads the counters one 32-bit word at a time through a simple read port. The result appears one cycle after the request. A read that coincides with an event on the same counter returns the value before that event.

Top module: `rxs_counter_bank`

## Requirements
- R1: Each event increments exactly one size-bin counter, chosen by the length including FCS. The bins and their word addresses are: 64 exactly (0), 65..127 (1), 128..255 (2), 256..511 (3), 512..1023 (4), and 1024 or more (5).
- R2: An event whose length including FCS is below 64 increments no size-bin counter.
- R3: Every event increments both the total-packets counter (address 6) and the good-packets counter (address 7) by one.
- R4: The kind input is encoded 2'b10 for broadcast, 2'b01 for multicast, and 2'b00 or 2'b11 for unicast. Broadcast increments the broadcast counter (address 8). Multicast increments the multicast counter (address 9). Unicast changes neither.
- R5: There are two 64-bit octet counters, total (low word 10, high word 11) and good (low word 12, high word 13). Each event adds the length without FCS plus 4 to both.
- R6: Every counter stops at its all-ones maximum. An addition that would pass the maximum leaves the counter at the maximum.
- R7: A read request with rd_en high captures the addressed word at the clock edge, and rd_data shows it until the next request. Addresses 14 and 15 read as zero. An event in the same cycle as the read returns the value before the update.
- R8: Reset clears every counter and rd_data to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | One-cycle pulse for each accepted frame |
| ev_len_nofcs | input | LEN_W | Frame length in bytes, FCS excluded |
| ev_len_fcs | input | LEN_W | Frame length in bytes, FCS included |
| ev_kind | input | 2 | Destination kind: 2'b10 broadcast, 2'b01 multicast, otherwise unicast |
| rd_en | input | 1 | Read request |
| rd_addr | input | 4 | Word address of the counter to read |
| rd_data | output | 32 | Read word, registered |

## Verification
The assertions assume two things about the inputs. First, ev_len_fcs is exactly 4 more than ev_len_nofcs. Second, both values fit in LEN_W bits. The assertions also assume that ev_valid lasts only a single cycle per frame. The stimulus table derives each length without FCS from the length with FCS. Every event pulse is driven for one clock and then dropped. Saturation is reached on a second instance with narrow counters, which is fed the same event stream.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
    localparam int NBINS   = 6;
    localparam int NWORDS  = 16;
    localparam int ADDR_W  = $clog2(NWORDS);
    localparam int FCS_LEN = 4;

    localparam logic [ADDR_W-1:0] A_TOTAL_PKT = 4'd6;
    localparam logic [ADDR_W-1:0] A_GOOD_PKT  = 4'd7;
    localparam logic [ADDR_W-1:0] A_BCAST     = 4'd8;
    localparam logic [ADDR_W-1:0] A_MCAST     = 4'd9;
    localparam logic [ADDR_W-1:0] A_TOCT_LO   = 4'd10;
    localparam logic [ADDR_W-1:0] A_TOCT_HI   = 4'd11;
    localparam logic [ADDR_W-1:0] A_GOCT_LO   = 4'd12;
    localparam logic [ADDR_W-1:0] A_GOCT_HI   = 4'd13;

    typedef enum logic [1:0] {
        KIND_UNI  = 2'b00,
        KIND_MULT = 2'b01,
        KIND_BRD  = 2'b10,
        KIND_RSVD = 2'b11
    } rx_kind_e;

    function automatic int bin_floor(input int idx);
        case (idx)
            0:       return 64;
            1:       return 65;
            2:       return 128;
            3:       return 256;
            4:       return 512;
            default: return 1024;
        endcase
    endfunction
endpackage

// File: rtl/rxs_bin_sel.sv
module rxs_bin_sel #(
    parameter int LEN_W = 16
) (
    input  logic [LEN_W-1:0]          len_fcs,
    output logic [rxs_pkg::NBINS-1:0] bin_hit
);
    import rxs_pkg::*;

    logic [31:0] len32;
    assign len32 = 32'(len_fcs);

    for (genvar i = 0; i < NBINS; i++) begin : g_bin
        if (i == NBINS - 1) begin : g_top
            assign bin_hit[i] = (len32 >= 32'(bin_floor(i)));
        end else begin : g_mid
            assign bin_hit[i] = (len32 >= 32'(bin_floor(i))) &&
                                (len32 <  32'(bin_floor(i + 1)));
        end
    end

    always_comb begin
        a_r1_one_bin: assert ($onehot0(bin_hit));
        if (len32 < 32'd64) begin
            a_r2_short_no_bin: assert (bin_hit == '0);
        end
    end
endmodule

// File: rtl/rxs_sat_ctr.sv
module rxs_sat_ctr #(
    parameter int W     = 32,
    parameter int INC_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [INC_W-1:0] amt,
    output logic [W-1:0]     cnt
);
    localparam int SUM_W = ((W > INC_W) ? W : INC_W) + 1;

    logic [W-1:0]     cnt_d, cnt_q;
    logic [SUM_W-1:0] sum;

    always_comb begin
        sum   = SUM_W'(cnt_q) + SUM_W'(amt);
        cnt_d = cnt_q;
        if (en) begin
            cnt_d = (sum > SUM_W'({W{1'b1}})) ? {W{1'b1}} : sum[W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cnt_q >= $past(cnt_q));
    a_r6_hold_max: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == {W{1'b1}}) |=> (cnt_q == {W{1'b1}}));
endmodule

// File: rtl/rxs_counter_bank.sv
module rxs_counter_bank #(
    parameter int LEN_W = 16,
    parameter int PKT_W = 32,
    parameter int OCT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_valid,
    input  logic [LEN_W-1:0] ev_len_nofcs,
    input  logic [LEN_W-1:0] ev_len_fcs,
    input  logic [1:0]       ev_kind,
    input  logic             rd_en,
    input  logic [3:0]       rd_addr,
    output logic [31:0]      rd_data
);
    import rxs_pkg::*;

    localparam int AMT_W = LEN_W + 1;
    localparam int NPKT  = 4;

    typedef struct packed {
        logic [31:0] rd_data;
    } rd_state_t;

    rd_state_t            st_d, st_q;
    logic [NBINS-1:0]     bin_hit;
    logic [PKT_W-1:0]     bin_cnt [NBINS];
    logic [PKT_W-1:0]     pkt_cnt [NPKT];
    logic [NPKT-1:0]      pkt_en;
    logic [OCT_W-1:0]     tot_oct, good_oct;
    logic [AMT_W-1:0]     oct_amt;
    logic [63:0]          tot_ext, good_ext;

    rxs_bin_sel #(.LEN_W(LEN_W)) u_bin (
        .len_fcs (ev_len_fcs),
        .bin_hit (bin_hit)
    );

    for (genvar i = 0; i < NBINS; i++) begin : g_bins
        rxs_sat_ctr #(.W(PKT_W), .INC_W(1)) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (ev_valid && bin_hit[i]),
            .amt   (1'b1),
            .cnt   (bin_cnt[i])
        );
    end

    assign pkt_en[0] = ev_valid;
    assign pkt_en[1] = ev_valid;
    assign pkt_en[2] = ev_valid && (ev_kind == KIND_BRD);
    assign pkt_en[3] = ev_valid && (ev_kind == KIND_MULT);

    for (genvar j = 0; j < NPKT; j++) begin : g_pkts
        rxs_sat_ctr #(.W(PKT_W), .INC_W(1)) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (pkt_en[j]),
            .amt   (1'b1),
            .cnt   (pkt_cnt[j])
        );
    end

    assign oct_amt = AMT_W'(ev_len_nofcs) + AMT_W'(FCS_LEN);

    rxs_sat_ctr #(.W(OCT_W), .INC_W(AMT_W)) u_tot_oct (
        .clk (clk), .rst_n (rst_n), .en (ev_valid), .amt (oct_amt), .cnt (tot_oct)
    );
    rxs_sat_ctr #(.W(OCT_W), .INC_W(AMT_W)) u_good_oct (
        .clk (clk), .rst_n (rst_n), .en (ev_valid), .amt (oct_amt), .cnt (good_oct)
    );

    assign tot_ext  = 64'(tot_oct);
    assign good_ext = 64'(good_oct);

    always_comb begin
        st_d = st_q;
        if (rd_en) begin
            st_d.rd_data = '0;
            if (rd_addr < 4'(NBINS)) begin
                st_d.rd_data = 32'(bin_cnt[rd_addr[2:0]]);
            end else begin
                case (rd_addr)
                    A_TOTAL_PKT: st_d.rd_data = 32'(pkt_cnt[0]);
                    A_GOOD_PKT:  st_d.rd_data = 32'(pkt_cnt[1]);
                    A_BCAST:     st_d.rd_data = 32'(pkt_cnt[2]);
                    A_MCAST:     st_d.rd_data = 32'(pkt_cnt[3]);
                    A_TOCT_LO:   st_d.rd_data = tot_ext[31:0];
                    A_TOCT_HI:   st_d.rd_data = tot_ext[63:32];
                    A_GOCT_LO:   st_d.rd_data = good_ext[31:0];
                    A_GOCT_HI:   st_d.rd_data = good_ext[63:32];
                    default:     st_d.rd_data = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.rd_data;

    a_r3_total_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && pkt_cnt[0] != {PKT_W{1'b1}}) |=> pkt_cnt[0] == $past(pkt_cnt[0]) + 1'b1);
    a_r3_total_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_valid |=> $stable(pkt_cnt[0]) && $stable(pkt_cnt[1]));
    a_r4_unicast_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_kind[1] == ev_kind[0]) |=> $stable(pkt_cnt[2]) && $stable(pkt_cnt[3]));
    a_r5_octets_match: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> tot_oct == good_oct);
    a_r7_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
    a_r8_reset_clear: assert property (@(posedge clk)
        !rst_n |=> rd_data == '0 && pkt_cnt[0] == '0 && tot_oct == '0);
endmodule

// File: tb/rxs_counter_bank_bench.sv
module rxs_counter_bank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_valid = 1'b0;
    logic [15:0] ev_len_nofcs = '0;
    logic [15:0] ev_len_fcs = '0;
    logic [1:0]  ev_kind = '0;
    logic        rd_en = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data, rd_data_s;

    int total = 0;
    int bad = 0;
    longint unsigned exp_w [14];

    always #2 clk = ~clk;

    rxs_counter_bank u_rxs_counter_bank (
        .clk (clk), .rst_n (rst_n), .ev_valid (ev_valid),
        .ev_len_nofcs (ev_len_nofcs), .ev_len_fcs (ev_len_fcs),
        .ev_kind (ev_kind), .rd_en (rd_en), .rd_addr (rd_addr), .rd_data (rd_data)
    );

    rxs_counter_bank #(.LEN_W(8), .PKT_W(4), .OCT_W(10)) u_rxs_counter_bank_sat (
        .clk (clk), .rst_n (rst_n), .ev_valid (ev_valid),
        .ev_len_nofcs (ev_len_nofcs[7:0]), .ev_len_fcs (ev_len_fcs[7:0]),
        .ev_kind (ev_kind), .rd_en (rd_en), .rd_addr (rd_addr), .rd_data (rd_data_s)
    );

    // {len_fcs, kind, expected bin (7 = none)}
    localparam int NVEC = 14;
    localparam logic [20:0] VEC [NVEC] = '{
        {16'd60,   2'b00, 3'd7}, {16'd63,   2'b10, 3'd7},
        {16'd64,   2'b01, 3'd0}, {16'd65,   2'b00, 3'd1},
        {16'd127,  2'b11, 3'd1}, {16'd128,  2'b10, 3'd2},
        {16'd255,  2'b01, 3'd2}, {16'd256,  2'b00, 3'd3},
        {16'd511,  2'b00, 3'd3}, {16'd512,  2'b01, 3'd4},
        {16'd1023, 2'b10, 3'd4}, {16'd1024, 2'b00, 3'd5},
        {16'd1522, 2'b01, 3'd5}, {16'd9000, 2'b00, 3'd5}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_read(input logic [3:0] a, output logic [31:0] d, output logic [31:0] ds);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data; ds = rd_data_s;
    endtask

    task automatic send(input logic [15:0] lf, input logic [1:0] k);
        @(negedge clk);
        ev_valid = 1'b1; ev_len_fcs = lf; ev_len_nofcs = lf - 16'd4; ev_kind = k;
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    function automatic logic [31:0] exp_word(input int a);
        if (a == 10) return exp_w[10][31:0];
        if (a == 11) return exp_w[10][63:32];
        if (a == 12) return exp_w[12][31:0];
        if (a == 13) return exp_w[12][63:32];
        return exp_w[a][31:0];
    endfunction

    task automatic compare_all(input string tag);
        logic [31:0] d, ds;
        for (int a = 0; a < 14; a++) begin
            do_read(4'(a), d, ds);
            if (a < 6)       check({tag, " R1 bin"}, d, exp_word(a));
            else if (a < 8)  check({tag, " R3 pkts"}, d, exp_word(a));
            else if (a < 10) check({tag, " R4 kind"}, d, exp_word(a));
            else             check({tag, " R5 octets"}, d, exp_word(a));
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d, ds;
        for (int a = 0; a < 14; a++) exp_w[a] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R8: reset state
        do_read(4'd6, d, ds);  check("R8 reset total", d, 32'd0);
        do_read(4'd10, d, ds); check("R8 reset octets", d, 32'd0);

        // Vector walk: R1, R2, R3, R4, R5
        for (int v = 0; v < NVEC; v++) begin
            logic [15:0] lf;
            logic [1:0]  k;
            logic [2:0]  b;
            {lf, k, b} = VEC[v];
            send(lf, k);
            if (b != 3'd7) exp_w[b]++;
            exp_w[6]++; exp_w[7]++;
            if (k == 2'b10) exp_w[8]++;
            if (k == 2'b01) exp_w[9]++;
            exp_w[10] += longint'(lf - 16'd4) + 4;
            exp_w[12] += longint'(lf - 16'd4) + 4;
            if (v == 1) begin
                // R2: two short frames so far, no bin touched
                for (int a = 0; a < 6; a++) begin
                    do_read(4'(a), d, ds);
                    check("R2 short no bin", d, 32'd0);
                end
            end
            compare_all($sformatf("vec%0d", v));
        end

        // R7: unmapped addresses read zero
        do_read(4'd14, d, ds); check("R7 unmapped 14", d, 32'd0);
        do_read(4'd15, d, ds); check("R7 unmapped 15", d, 32'd0);

        // R7: read and event in the same cycle return the old value
        @(negedge clk);
        rd_en = 1'b1; rd_addr = 4'd6;
        ev_valid = 1'b1; ev_len_fcs = 16'd100; ev_len_nofcs = 16'd96; ev_kind = 2'b00;
        @(negedge clk);
        rd_en = 1'b0; ev_valid = 1'b0;
        check("R7 same-cycle old value", rd_data, exp_w[6][31:0]);
        exp_w[1]++; exp_w[6]++; exp_w[7]++; exp_w[10] += 100; exp_w[12] += 100;
        repeat (3) @(negedge clk);
        check("R7 read data held", rd_data, exp_w[6][31:0] - 32'd1);
        do_read(4'd6, d, ds); check("R7 updated total", d, exp_w[6][31:0]);

        // R6: saturation on the narrow instance after reset
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        do_read(4'd7, d, ds); check("R8 reset good pkts", d, 32'd0);
        for (int n = 0; n < 20; n++) send(16'd200, 2'b10);
        do_read(4'd6, d, ds);
        check("R6 narrow pkt saturate", ds, 32'd15);
        check("R3 wide total after 20", d, 32'd20);
        do_read(4'd8, d, ds);  check("R6 narrow bcast saturate", ds, 32'd15);
        do_read(4'd2, d, ds);  check("R6 narrow bin saturate", ds, 32'd15);
        do_read(4'd10, d, ds);
        check("R6 narrow octet saturate", ds, 32'd1023);
        check("R5 wide octets 20x200", d, 32'd4000);
        do_read(4'd11, d, ds); check("R5 octet high word", d, 32'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule